// File: doc/BRIEF.md
# Edge-Armed Manual Word Aligner

This block takes the parallel words coming out of a deserializer, whose bit boundary is unknown, and recovers the true word boundary. It slides a fixed alignment pattern across every bit position of a short history window. When the pattern turns up while a search is open, the block locks onto that position. From then on it delivers words cut at that position. Each output word carries a pattern-detect flag and a sync-status flag, and both sit in the byte lane that holds the pattern's top byte.

A search is open only in two cases: right after the synchronous reset is released, or after a low-to-high transition on the realign enable. A high level on that input does nothing. Once the block is locked, the pattern can appear at another bit position and the locked boundary still does not move. The pattern is a parameter, 16 bits wide by default (value 16'hF628), and may also be 32 bits. The pattern width must be a multiple of the word width.

Top module: `word_aligner`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `word_o`, `pat_det_o` and `sync_ok_o` are all zero. The selected boundary restarts at offset 0 and a search is open.
- R2: After reset release the block locks to the first pattern found, whatever level `realign_en_i` has.
- R3: While locked, a pattern at a different bit offset is ignored. It raises no flag and does not change the boundary used for `word_o`.
- R4: Each pattern seen at the locked offset raises `pat_det_o` for that one output cycle. The flag is on bit 1, the lane of the pattern's upper byte, and bit 0 stays low.
- R5: `sync_ok_o` is 2'b10 from the locking cycle until a rising edge of `realign_en_i`. In the output cycle of that edge it is 2'b00, unless a pattern completes in the same cycle.
- R6: Holding `realign_en_i` high does not reopen the search. Only a low-to-high transition seen at a clock edge does.
- R7: After a rising edge the block locks to the first pattern that completes at or after the edge cycle, at whatever offset it has. A pattern that completes in the edge cycle itself counts.
- R8: If the pattern matches at several offsets in the same cycle, the lowest offset wins.
- R9: The stream is read LSB-first, with the current word above the previous one. A match at offset k means bits [k+15:k] of {current, previous} equal the pattern. `word_o` shows those bits one cycle later, in the same cycle as its two flags.
- R10: While a search is open, `word_o` is cut at the last locked offset, or at offset 0 if nothing has locked since reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel word clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_word_i | input | 16 | Raw deserialized word, arbitrary bit offset |
| realign_en_i | input | 1 | Realign request, acts on its rising edge |
| word_o | output | 16 | Word cut at the selected boundary |
| pat_det_o | output | 2 | Per-lane pattern-detect pulse |
| sync_ok_o | output | 2 | Per-lane sync-status flag |

## Verification
A rising edge on the realign enable and the completion of a pattern can fall in the same cycle. The edge would clear sync-status, while the match must relock and keep it high. The bench sets this up by sending the first half of a pattern at a new offset with the enable low. In the next cycle it sends the second half and raises the enable. The result is judged by expecting sync-status to stay at 2'b10 with no dip, a detect pulse, and the word cut at the new offset, all in the following output cycle.

// File: rtl/wa_pkg.sv
package wa_pkg;

    localparam int LANE_W      = 8;
    localparam int DEF_DATA_W  = 16;
    localparam int DEF_PAT_W   = 16;

    typedef enum logic {
        ST_HUNT   = 1'b0,
        ST_LOCKED = 1'b1
    } wa_state_e;

    // number of earlier words the history must keep for a pattern to fit at any offset
    function automatic int hist_words(input int pat_w, input int data_w);
        return pat_w / data_w;
    endfunction

endpackage

// File: rtl/wa_edge.sv
module wa_edge (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic rise_o
);

    logic en_q;

    // tracked during reset too, so a transition made while in reset is absorbed
    always_ff @(posedge clk) begin
        en_q <= en_i;
    end

    assign rise_o = en_i & ~en_q;

    // R6: a rise is a single-cycle event
    p_rise_single_r6: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/wa_match.sv
module wa_match #(
    parameter int DATA_W = 16,
    parameter int PAT_W  = 16,
    parameter int WIN_W  = 32,
    parameter int OFF_W  = 4,
    parameter logic [PAT_W-1:0] PATTERN = 16'hF628
) (
    input  logic [WIN_W-1:0]  win_i,
    output logic [DATA_W-1:0] hit_vec_o,
    output logic              any_hit_o,
    output logic [OFF_W-1:0]  low_off_o
);

    for (genvar k = 0; k < DATA_W; k++) begin : g_cmp
        assign hit_vec_o[k] = (win_i[k +: PAT_W] == PATTERN);
    end

    assign any_hit_o = |hit_vec_o;

    // lowest offset wins
    always_comb begin
        low_off_o = '0;
        for (int k = DATA_W - 1; k >= 0; k--) begin
            if (hit_vec_o[k]) low_off_o = OFF_W'(k);
        end
    end

endmodule

// File: rtl/wa_ctrl.sv
module wa_ctrl
    import wa_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int OFF_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise_i,
    input  logic [DATA_W-1:0] hit_vec_i,
    input  logic              any_hit_i,
    input  logic [OFF_W-1:0]  low_off_i,
    output logic [OFF_W-1:0]  sel_off_o,
    output logic              det_o,
    output logic              sts_o
);

    wa_state_e        state_q;
    logic [OFF_W-1:0] off_q;
    logic             hunt;
    logic             take;

    assign hunt      = (state_q == ST_HUNT) || rise_i;
    assign take      = hunt && any_hit_i;
    assign sel_off_o = take ? low_off_i : off_q;
    assign det_o     = take || (!hunt && hit_vec_i[off_q]);
    assign sts_o     = take || !hunt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
            off_q   <= '0;
        end else if (take) begin
            state_q <= ST_LOCKED;
            off_q   <= low_off_i;
        end else if (rise_i) begin
            state_q <= ST_HUNT;
        end
    end

    // R2: an open search with a match always ends locked
    p_lock_on_hit_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HUNT && any_hit_i) |=> state_q == ST_LOCKED);

    // R3: a locked boundary holds unless the enable rises
    p_hold_boundary_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOCKED && !rise_i) |=> $stable(off_q));

    // R5: an edge with no match reopens the search
    p_edge_reopens_r5: assert property (@(posedge clk) disable iff (rst)
        (rise_i && !any_hit_i) |=> state_q == ST_HUNT);

endmodule

// File: rtl/word_aligner.sv
module word_aligner
    import wa_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int PAT_W  = DEF_PAT_W,
    parameter logic [PAT_W-1:0] PATTERN = 16'hF628
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] rx_word_i,
    input  logic              realign_en_i,
    output logic [DATA_W-1:0] word_o,
    output logic [DATA_W/LANE_W-1:0] pat_det_o,
    output logic [DATA_W/LANE_W-1:0] sync_ok_o
);

    localparam int LANES  = DATA_W / LANE_W;
    localparam int NPREV  = hist_words(PAT_W, DATA_W);
    localparam int HIST_W = NPREV * DATA_W;
    localparam int WIN_W  = HIST_W + DATA_W;
    localparam int OFF_W  = $clog2(DATA_W);
    localparam int BASE   = PAT_W - DATA_W;
    localparam logic [LANES-1:0] TOP_LANE = LANES'(1) << (LANES - 1);

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic [LANES-1:0]  det;
        logic [LANES-1:0]  sts;
    } beat_t;

    logic [HIST_W-1:0] hist_q;
    logic [WIN_W-1:0]  win;
    logic [WIN_W-1:0]  shifted;
    logic [DATA_W-1:0] hit_vec;
    logic              any_hit;
    logic [OFF_W-1:0]  low_off;
    logic [OFF_W-1:0]  sel_off;
    logic              rise;
    logic              det_n;
    logic              sts_n;
    beat_t             beat_d;
    beat_t             beat_q;

    assign win = {rx_word_i, hist_q};

    always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= win[WIN_W-1:DATA_W];
    end

    wa_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .en_i   (realign_en_i),
        .rise_o (rise)
    );

    wa_match #(
        .DATA_W  (DATA_W),
        .PAT_W   (PAT_W),
        .WIN_W   (WIN_W),
        .OFF_W   (OFF_W),
        .PATTERN (PATTERN)
    ) u_match (
        .win_i     (win),
        .hit_vec_o (hit_vec),
        .any_hit_o (any_hit),
        .low_off_o (low_off)
    );

    wa_ctrl #(
        .DATA_W (DATA_W),
        .OFF_W  (OFF_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .rise_i    (rise),
        .hit_vec_i (hit_vec),
        .any_hit_i (any_hit),
        .low_off_i (low_off),
        .sel_off_o (sel_off),
        .det_o     (det_n),
        .sts_o     (sts_n)
    );

    // barrel cut: the output word ends with the pattern's top byte
    assign shifted = win >> (int'(sel_off) + BASE);

    always_comb begin
        beat_d.word = shifted[DATA_W-1:0];
        beat_d.det  = det_n ? TOP_LANE : '0;
        beat_d.sts  = sts_n ? TOP_LANE : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) beat_q <= '0;
        else     beat_q <= beat_d;
    end

    assign word_o    = beat_q.word;
    assign pat_det_o = beat_q.det;
    assign sync_ok_o = beat_q.sts;

    // R4: only the top lane ever carries a flag
    p_low_lanes_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        ((pat_det_o & ~TOP_LANE) == '0) && ((sync_ok_o & ~TOP_LANE) == '0));

    // R5: a detect pulse is always accompanied by sync-status
    p_det_implies_sync_r5: assert property (@(posedge clk) disable iff (rst)
        (pat_det_o != '0) |-> (sync_ok_o == TOP_LANE));

    // R1: first cycle out of reset shows cleared outputs
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (word_o == '0 && pat_det_o == '0 && sync_ok_o == '0));

endmodule

// File: tb/test_word_aligner.sv
`timescale 1ns/1ps
module test_word_aligner;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] rx;
    logic [15:0] rx2;
    logic        en;
    logic [15:0] word_o,  word2;
    logic [1:0]  det_o,   det2;
    logic [1:0]  sts_o,   sts2;

    int tests  = 0;
    int failed = 0;

    always #2.5 clk = ~clk;

    word_aligner i_word_aligner (
        .clk          (clk),
        .rst          (rst),
        .rx_word_i    (rx),
        .realign_en_i (en),
        .word_o       (word_o),
        .pat_det_o    (det_o),
        .sync_ok_o    (sts_o)
    );

    // second instance with a pattern that matches at two offsets at once
    word_aligner #(.PATTERN(16'h0101)) i_word_aligner_dup (
        .clk          (clk),
        .rst          (rst),
        .rx_word_i    (rx2),
        .realign_en_i (1'b0),
        .word_o       (word2),
        .pat_det_o    (det2),
        .sync_ok_o    (sts2)
    );

    typedef struct packed {
        logic [15:0] word;
        logic        en;
        logic [15:0] exp_word;
        logic [1:0]  exp_det;
        logic [1:0]  exp_sts;
        logic [3:0]  req;
    } row_t;

    localparam int NROWS = 21;
    localparam row_t ROWS [NROWS] = '{
        '{16'h1111, 1'b0, 16'h0000, 2'b00, 2'b00, 4'd1},  // R1 search open, nothing yet
        '{16'h6280, 1'b0, 16'h1111, 2'b00, 2'b00, 4'd10}, // R10 offset 0 before lock
        '{16'h000F, 1'b0, 16'hF628, 2'b10, 2'b10, 4'd2},  // R2 lock at offset 4, enable low
        '{16'h0000, 1'b0, 16'h0000, 2'b00, 2'b10, 4'd9},  // R9 flag lasted one cycle
        '{16'h2800, 1'b0, 16'h0000, 2'b00, 2'b10, 4'd3},  // R3
        '{16'h00F6, 1'b0, 16'h6280, 2'b00, 2'b10, 4'd3},  // R3 offset-8 pattern ignored
        '{16'h0000, 1'b0, 16'h000F, 2'b00, 2'b10, 4'd3},  // R3 still cut at offset 4
        '{16'h6280, 1'b0, 16'h0000, 2'b00, 2'b10, 4'd4},  // R4
        '{16'h000F, 1'b0, 16'hF628, 2'b10, 2'b10, 4'd4},  // R4 repeat at locked offset
        '{16'h0000, 1'b0, 16'h0000, 2'b00, 2'b10, 4'd5},  // R5 status held
        '{16'h1234, 1'b1, 16'h4000, 2'b00, 2'b00, 4'd5},  // R5 edge drops status
        '{16'h2800, 1'b1, 16'h0123, 2'b00, 2'b00, 4'd10}, // R10 search keeps offset 4
        '{16'h00F6, 1'b1, 16'hF628, 2'b10, 2'b10, 4'd7},  // R7 relock at offset 8
        '{16'h0000, 1'b1, 16'h0000, 2'b00, 2'b10, 4'd6},  // R6
        '{16'h6280, 1'b1, 16'h8000, 2'b00, 2'b10, 4'd6},  // R6 level high, no search
        '{16'h000F, 1'b1, 16'h0F62, 2'b00, 2'b10, 4'd6},  // R6 offset-4 pattern ignored
        '{16'h0000, 1'b1, 16'h0000, 2'b00, 2'b10, 4'd6},  // R6
        '{16'h0000, 1'b0, 16'h0000, 2'b00, 2'b10, 4'd6},  // R6 enable falls, nothing changes
        '{16'h6280, 1'b0, 16'h8000, 2'b00, 2'b10, 4'd7},  // R7
        '{16'h000F, 1'b1, 16'hF628, 2'b10, 2'b10, 4'd7},  // R7 edge and pattern together
        '{16'h0000, 1'b1, 16'h0000, 2'b00, 2'b10, 4'd7}   // R7 now cut at offset 4
    };

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [15:0] w, input logic [15:0] w2, input logic e);
        @(negedge clk);
        rx  = w;
        rx2 = w2;
        en  = e;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    endtask

    initial begin
        #1000000;
        tests++;
        failed++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        rx  = '0;
        rx2 = '0;
        en  = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(word_o, 16'h0000, "R1 word in reset");
        chk({14'd0, det_o}, 16'h0, "R1 detect in reset");
        chk({14'd0, sts_o}, 16'h0, "R1 status in reset");
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NROWS; i++) begin
            step(ROWS[i].word, 16'h0000, ROWS[i].en);
            chk(word_o, ROWS[i].exp_word, $sformatf("R%0d row %0d word", ROWS[i].req, i));
            chk({14'd0, det_o}, {14'd0, ROWS[i].exp_det}, $sformatf("R%0d row %0d detect", ROWS[i].req, i));
            chk({14'd0, sts_o}, {14'd0, ROWS[i].exp_sts}, $sformatf("R%0d row %0d status", ROWS[i].req, i));
        end

        // R1 reset from a locked state clears everything
        @(negedge clk);
        rst = 1'b1;
        rx  = 16'hFFFF;
        @(posedge clk);
        #1;
        chk(word_o, 16'h0000, "R1 word after mid-run reset");
        chk({14'd0, sts_o}, 16'h0, "R1 status after mid-run reset");
        @(negedge clk);
        rx  = '0;
        en  = 1'b0;
        rst = 1'b0;

        // R8 two offsets match at once: lowest must be taken
        step(16'h0000, 16'h0101, 1'b0);
        chk({14'd0, det2}, 16'h0, "R8 no match on first half");
        step(16'h0000, 16'h0101, 1'b0);
        chk({14'd0, det2}, 16'h2, "R8 detect on double match");
        chk(word2, 16'h0101, "R8 word on double match");
        step(16'h0000, 16'h0000, 1'b0);
        chk({14'd0, det2}, 16'h2, "R8 detect only at offset 0");
        chk(word2, 16'h0101, "R8 word cut at offset 0");

        finish_run();
    end

endmodule